// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block drives a word-wide NOR flash array built from several 16-bit devices placed side by side, with two lanes by default. A requester hands it one operation at a time through a valid/ready handshake. The operation is a single-word program, a block erase or an identifier read. The sequencer writes the command cycles on a simple synchronous memory bus and polls the device status until every lane reports ready. It then puts the array back into read mode, judges the outcome and raises a one-cycle done pulse with an ok flag.

Every command byte is replicated into the low byte of each 16-bit lane, and every status bit is evaluated in every lane. A program counts as good only when no lane reports a program fault and a read of the word, taken after the array is back in read mode, equals the data that was written. If a status poll never shows ready within a limit set by an input, the operation is aborted with an error. After any failed operation, the next accepted request is first preceded by a status-clear command, so stale fault bits cannot spoil it.

Bus timing is fixed: a read issued in one cycle expects its data on `bus_rdata` throughout the following cycle.

Top module: `nfs_sequencer`

## Requirements
- R1: `req_ready` is high exactly while the sequencer is idle, including right after reset. A request is taken when `req_valid` and `req_ready` are both high, and the bus stays quiet while idle.
- R2: A command write places its byte in bits 7:0 of every 16-bit lane, with bits 15:8 of each lane zero. The codes are 0xFF read-array, 0x90 read-ID, 0x20 erase-setup, 0xD0 erase-confirm, 0x40 program-setup, 0x70 status-read and 0x50 status-clear.
- R3: An erase (`req_op` = 2'b01) writes erase-setup and then erase-confirm, both to `req_addr`.
- R4: A program (`req_op` = 2'b00) writes program-setup and then `req_data`, both to `req_addr`.
- R5: After the start cycles, each poll is a status-read write followed by a read, both at the target address. Polling stops once bit 7 of every lane (bits 7 and 23 with two lanes) is set.
- R6: The last bus write before every done pulse is read-array. For program and erase it is written to the target address once polling ends.
- R7: An erase fails when bit 5 of any lane (bits 5 or 21) is set in the ready status word. Bit 4 does not fail an erase.
- R8: A program fails when bit 4 of any lane (bits 4 or 20) is set in the ready status word. It also fails when a read of the word, issued right after read-array, differs from `req_data`.
- R9: An ID read (`req_op` 2'b10 or 2'b11) writes read-ID to word 0, reads words 0 and 1, then writes read-array to word 0. It holds the two words on `id_word0` and `id_word1` and always reports ok.
- R10: At most max(`poll_limit`,1) polls are made. If none shows ready, the operation fails, and read-array is still written.
- R11: `done` is a single-cycle pulse and `ok` is high only together with a successful `done`.
- R12: After a failed operation, the next accepted request starts with a status-clear write to its own target address (word 0 for ID reads). After a successful operation, no status-clear is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | 00 program, 01 erase, 1x ID read |
| req_addr | input | AW | Target word address |
| req_data | input | DW | Word to program |
| poll_limit | input | PW | Maximum number of status polls (0 acts as 1) |
| bus_en | output | 1 | Bus cycle strobe |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Bus word address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid the cycle after a read |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Completion without error |
| id_word0 | output | DW | Identifier word at offset 0 |
| id_word1 | output | DW | Identifier word at offset 1 |

## Verification
The bench builds the sequencer with an 8-bit word address, two lanes and a 4-bit poll limit. The narrow limit makes the limit of zero and the edge where the busy count equals the limit quick to reach, so both timeout and the last successful poll are covered. Because the address space is only 256 words, the behavioural flash can keep the whole array and compute readback faults from its AND-only programming. This also lets a stale program-fault bit, left by an erase that passed, be carried into a later program.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
   localparam int LANE_W = 16;

   localparam logic [7:0] CMD_ARRAY  = 8'hFF;
   localparam logic [7:0] CMD_IDENT  = 8'h90;
   localparam logic [7:0] CMD_ERSET  = 8'h20;
   localparam logic [7:0] CMD_ERCONF = 8'hD0;
   localparam logic [7:0] CMD_PGSET  = 8'h40;
   localparam logic [7:0] CMD_STAT   = 8'h70;
   localparam logic [7:0] CMD_CLEAR  = 8'h50;

   localparam int BIT_READY = 7;
   localparam int BIT_ERFLT = 5;
   localparam int BIT_PGFLT = 4;

   typedef enum logic [3:0] {
      S_IDLE, S_CLR, S_SETUP, S_ISSUE, S_STAT, S_SREAD, S_SWAIT,
      S_ARRAY, S_RBREAD, S_RBWAIT, S_IDR0, S_IDR1, S_IDW1, S_DONE
   } seq_st_e;
endpackage

// File: rtl/nfs_lane_status.sv
module nfs_lane_status
   import nfs_pkg::*;
(
   input  logic [LANE_W-1:0] rd_lane,
   input  logic [LANE_W-1:0] wr_lane,
   output logic              rdy,
   output logic              er_flt,
   output logic              pg_flt,
   output logic              diff
);
   always_comb begin
      rdy    = rd_lane[BIT_READY];
      er_flt = rd_lane[BIT_ERFLT];
      pg_flt = rd_lane[BIT_PGFLT];
      diff   = (rd_lane != wr_lane);
   end
endmodule

// File: rtl/nfs_poll_ctr.sv
module nfs_poll_ctr #(
   parameter int PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   input  logic [PW-1:0] limit,
   output logic          last
);
   localparam int CW = PW + 1;

   logic [PW-1:0] cnt_q;
   logic [CW-1:0] eff_lim;

   always_comb begin
      eff_lim = (limit == '0) ? CW'(1) : {1'b0, limit};
      last    = ({1'b0, cnt_q} + CW'(1)) >= eff_lim;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else if (step)  cnt_q <= cnt_q + PW'(1);
   end
endmodule

// File: rtl/nfs_sequencer.sv
module nfs_sequencer
   import nfs_pkg::*;
#(
   parameter int AW    = 20,
   parameter int LANES = 2,
   parameter int PW    = 16,
   localparam int DW   = LANES * LANE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   input  logic [PW-1:0] poll_limit,
   output logic          bus_en,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   output logic          done,
   output logic          ok,
   output logic [DW-1:0] id_word0,
   output logic [DW-1:0] id_word1
);
   if (LANES < 1) begin : g_bad_lanes
      $error("nfs_sequencer: LANES must be at least 1");
   end
   if (AW < 1) begin : g_bad_aw
      $error("nfs_sequencer: AW must be at least 1");
   end
   if (PW < 1) begin : g_bad_pw
      $error("nfs_sequencer: PW must be at least 1");
   end

   function automatic logic [DW-1:0] cmd_word(input logic [7:0] code);
      logic [DW-1:0] w;
      w = '0;
      for (int l = 0; l < LANES; l++) w[l*LANE_W +: 8] = code;
      return w;
   endfunction

   seq_st_e       st_q;
   logic [1:0]    op_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic          stat_bad_q, tmo_q, rb_bad_q, err_pend_q;
   logic [DW-1:0] id0_q, id1_q;

   logic [LANES-1:0] rdy_v, er_v, pg_v, diff_v;
   logic all_rdy, any_er, any_pg, any_diff, poll_last, fail;
   logic is_prog, is_id;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      nfs_lane_status i_lane (
         .rd_lane (bus_rdata[l*LANE_W +: LANE_W]),
         .wr_lane (data_q[l*LANE_W +: LANE_W]),
         .rdy     (rdy_v[l]),
         .er_flt  (er_v[l]),
         .pg_flt  (pg_v[l]),
         .diff    (diff_v[l])
      );
   end

   nfs_poll_ctr #(.PW(PW)) i_poll (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (st_q == S_IDLE),
      .step  (st_q == S_SWAIT),
      .limit (poll_limit),
      .last  (poll_last)
   );

   always_comb begin
      all_rdy  = &rdy_v;
      any_er   = |er_v;
      any_pg   = |pg_v;
      any_diff = |diff_v;
      is_prog  = (op_q == 2'b00);
      is_id    = op_q[1];
      fail     = stat_bad_q | tmo_q | rb_bad_q;
   end

   always_comb begin
      bus_en    = 1'b0;
      bus_we    = 1'b0;
      bus_addr  = addr_q;
      bus_wdata = '0;
      unique case (st_q)
         S_CLR: begin
            bus_en = 1'b1; bus_we = 1'b1; bus_wdata = cmd_word(CMD_CLEAR);
         end
         S_SETUP: begin
            bus_en = 1'b1; bus_we = 1'b1;
            bus_wdata = is_id   ? cmd_word(CMD_IDENT) :
                        is_prog ? cmd_word(CMD_PGSET) : cmd_word(CMD_ERSET);
         end
         S_ISSUE: begin
            bus_en = 1'b1; bus_we = 1'b1;
            bus_wdata = is_prog ? data_q : cmd_word(CMD_ERCONF);
         end
         S_STAT: begin
            bus_en = 1'b1; bus_we = 1'b1; bus_wdata = cmd_word(CMD_STAT);
         end
         S_ARRAY: begin
            bus_en = 1'b1; bus_we = 1'b1; bus_wdata = cmd_word(CMD_ARRAY);
         end
         S_SREAD, S_RBREAD, S_IDR0: bus_en = 1'b1;
         S_IDR1: begin
            bus_en = 1'b1; bus_addr = AW'(1);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         op_q       <= '0;
         addr_q     <= '0;
         data_q     <= '0;
         stat_bad_q <= 1'b0;
         tmo_q      <= 1'b0;
         rb_bad_q   <= 1'b0;
         err_pend_q <= 1'b0;
         id0_q      <= '0;
         id1_q      <= '0;
      end else begin
         unique case (st_q)
            S_IDLE: if (req_valid) begin
               op_q       <= req_op;
               addr_q     <= req_op[1] ? '0 : req_addr;
               data_q     <= req_data;
               stat_bad_q <= 1'b0;
               tmo_q      <= 1'b0;
               rb_bad_q   <= 1'b0;
               st_q       <= err_pend_q ? S_CLR : S_SETUP;
            end
            S_CLR: begin
               err_pend_q <= 1'b0;
               st_q       <= S_SETUP;
            end
            S_SETUP: st_q <= is_id ? S_IDR0 : S_ISSUE;
            S_ISSUE: st_q <= S_STAT;
            S_STAT:  st_q <= S_SREAD;
            S_SREAD: st_q <= S_SWAIT;
            S_SWAIT: begin
               if (all_rdy) begin
                  stat_bad_q <= is_prog ? any_pg : any_er;
                  st_q       <= S_ARRAY;
               end else if (poll_last) begin
                  tmo_q <= 1'b1;
                  st_q  <= S_ARRAY;
               end else begin
                  st_q <= S_STAT;
               end
            end
            S_ARRAY:  st_q <= is_prog ? S_RBREAD : S_DONE;
            S_RBREAD: st_q <= S_RBWAIT;
            S_RBWAIT: begin
               rb_bad_q <= any_diff;
               st_q     <= S_DONE;
            end
            S_IDR0: st_q <= S_IDR1;
            S_IDR1: begin
               id0_q <= bus_rdata;
               st_q  <= S_IDW1;
            end
            S_IDW1: begin
               id1_q <= bus_rdata;
               st_q  <= S_ARRAY;
            end
            S_DONE: begin
               err_pend_q <= fail;
               st_q       <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready = (st_q == S_IDLE);
      done      = (st_q == S_DONE);
      ok        = done & ~fail;
      id_word0  = id0_q;
      id_word1  = id1_q;
   end
endmodule

// File: rtl/nfs_sequencer_chk.sv
module nfs_sequencer_chk
   import nfs_pkg::*;
#(
   parameter int AW    = 20,
   parameter int LANES = 2,
   parameter int PW    = 16,
   localparam int DW   = LANES * LANE_W
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic [PW-1:0] poll_limit,
   input logic          bus_en,
   input logic          bus_we,
   input logic [DW-1:0] bus_wdata,
   input logic          done
);
   localparam int CW = PW + 1;

   function automatic logic [DW-1:0] lane_cmd(input logic [7:0] code);
      logic [DW-1:0] w;
      w = '0;
      for (int l = 0; l < LANES; l++) w[l*LANE_W +: 8] = code;
      return w;
   endfunction

   logic [DW-1:0] last_wr_q;
   logic [CW-1:0] polls_q;
   logic [CW-1:0] eff_lim;
   logic          stat_wr;

   always_comb begin
      stat_wr = bus_en && bus_we && (bus_wdata == lane_cmd(CMD_STAT));
      eff_lim = (poll_limit == '0) ? CW'(1) : {1'b0, poll_limit};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_wr_q <= '0;
         polls_q   <= '0;
      end else begin
         if (bus_en && bus_we) last_wr_q <= bus_wdata;
         if (req_valid && req_ready) polls_q <= '0;
         else if (stat_wr)           polls_q <= polls_q + CW'(1);
      end
   end

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R1
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !bus_en); // R1
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11
   AST_DONE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> req_ready); // R11
   AST_ARRAY_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (last_wr_q == lane_cmd(CMD_ARRAY))); // R6
   AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |-> (polls_q < eff_lim)); // R10
endmodule

bind nfs_sequencer nfs_sequencer_chk #(.AW(AW), .LANES(LANES), .PW(PW)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .poll_limit (poll_limit),
   .bus_en     (bus_en),
   .bus_we     (bus_we),
   .bus_wdata  (bus_wdata),
   .done       (done)
);

// File: tb/test_nfs_sequencer.sv
module test_nfs_sequencer;
   localparam int AW = 8, LANES = 2, PW = 4, DW = 32;
   localparam logic [31:0] ID0 = 32'h00AB00AB, ID1 = 32'h5A6C5A6C;
   localparam int M_ARR = 0, M_STAT = 1, M_ID = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          req_valid = 1'b0, req_ready;
   logic [1:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic [PW-1:0] poll_limit = '0;
   logic          bus_en, bus_we, done, ok;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata, id_word0, id_word1;

   nfs_sequencer #(.AW(AW), .LANES(LANES), .PW(PW)) i_nfs_sequencer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
      .poll_limit(poll_limit), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .done(done), .ok(ok), .id_word0(id_word0), .id_word1(id_word1));

   int n_cmp = 0, n_bad = 0;

   task automatic chk(input bit cond, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!cond) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] cw(input logic [7:0] b);
      return {8'h00, b, 8'h00, b};
   endfunction

   // behavioural flash
   logic [31:0] fmem [256];
   int          mode = M_ARR, busy = 0, k_busy = 0;
   bit          pend_pg = 0, pend_er = 0;
   logic [31:0] sreg = '0, k_err = '0, k_flip = '0;
   logic [31:0] rd_pend = '0, rd_out = '0;
   assign bus_rdata = rd_out;

   task automatic f_write(input logic [7:0] a, input logic [31:0] d);
      if (pend_pg) begin
         fmem[a] = (fmem[a] & d) ^ k_flip;
         pend_pg = 0; busy = k_busy; sreg |= k_err; mode = M_STAT;
      end else if (pend_er && d == cw(8'hD0)) begin
         for (int i = 0; i < 16; i++) fmem[{a[7:4], 4'(i)}] = 32'hFFFF_FFFF;
         pend_er = 0; busy = k_busy; sreg |= k_err; mode = M_STAT;
      end else begin
         pend_er = 0;
         if (d == cw(8'h40)) pend_pg = 1;
         else if (d == cw(8'h20)) pend_er = 1;
         else if (d == cw(8'h70)) mode = M_STAT;
         else if (d == cw(8'hFF)) mode = M_ARR;
         else if (d == cw(8'h90)) mode = M_ID;
         else if (d == cw(8'h50)) sreg = '0;
      end
   endtask

   function automatic logic [31:0] f_read(input logic [7:0] a);
      if (mode == M_STAT) begin
         if (busy > 0) begin busy--; return 32'h0; end
         return 32'h0080_0080 | sreg;
      end
      if (mode == M_ID) return (a == 0) ? ID0 : (a == 1) ? ID1 : 32'h0;
      return fmem[a];
   endfunction

   // expected bus sequence
   logic [40:0] expq[$];
   bit          exp_pend = 0, exp_ok = 0, e_errpend = 0;
   logic [31:0] e_sticky = '0;
   string       cur_tag = "R1";

   always @(negedge clk) begin
      logic [40:0] e;
      rd_out  = rd_pend;
      rd_pend = '0;
      if (rst_n) begin
         if (bus_en) begin
            if (expq.size() == 0) begin
               chk(0, {cur_tag, " unexpected bus cycle"}, {bus_we, bus_addr, bus_wdata}, 0);
            end else begin
               e = expq.pop_front();
               chk(bus_we == e[40] && bus_addr == e[39:32] && (!bus_we || bus_wdata == e[31:0]),
                   {cur_tag, " bus cycle"}, {bus_we, bus_addr, bus_wdata}, e);
            end
            if (bus_we) f_write(bus_addr, bus_wdata);
            else        rd_pend = f_read(bus_addr);
         end
         if (done) begin
            chk(exp_pend && expq.size() == 0 && ok == exp_ok,
                {cur_tag, " R11 done/ok"}, {exp_pend, ok}, {1'b1, exp_ok});
            exp_pend = 0;
         end
      end
   end

   task automatic run_req(input logic [1:0] op, input logic [7:0] a, input logic [31:0] d,
                          input int lim, input int bsy, input logic [31:0] err,
                          input logic [31:0] flip, input string tag);
      logic [7:0] t;
      int eff, np;
      bit tmo;
      t = op[1] ? 8'h00 : a;
      k_busy = bsy; k_err = err; k_flip = flip; cur_tag = tag;
      if (e_errpend) begin
         expq.push_back({1'b1, t, cw(8'h50)});   // R12
         e_sticky = '0;
      end
      if (op[1]) begin
         expq.push_back({1'b1, t, cw(8'h90)});
         expq.push_back({1'b0, 8'd0, 32'h0});
         expq.push_back({1'b0, 8'd1, 32'h0});
         expq.push_back({1'b1, t, cw(8'hFF)});
         exp_ok = 1;
      end else begin
         eff = (lim == 0) ? 1 : lim;
         tmo = (bsy >= eff);
         np  = tmo ? eff : bsy + 1;
         e_sticky |= err;
         if (op == 2'b00) begin
            expq.push_back({1'b1, t, cw(8'h40)});
            expq.push_back({1'b1, t, d});
         end else begin
            expq.push_back({1'b1, t, cw(8'h20)});
            expq.push_back({1'b1, t, cw(8'hD0)});
         end
         for (int i = 0; i < np; i++) begin
            expq.push_back({1'b1, t, cw(8'h70)});
            expq.push_back({1'b0, t, 32'h0});
         end
         expq.push_back({1'b1, t, cw(8'hFF)});
         if (op == 2'b00) begin
            expq.push_back({1'b0, t, 32'h0});
            exp_ok = !tmo && (e_sticky & 32'h0010_0010) == 0 && (((fmem[t] & d) ^ flip) == d);
         end else begin
            exp_ok = !tmo && (e_sticky & 32'h0020_0020) == 0;
         end
      end
      e_errpend = !exp_ok;
      exp_pend = 1;
      @(negedge clk);
      req_op = op; req_addr = a; req_data = d; poll_limit = PW'(lim); req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (exp_pend) @(negedge clk);
      @(negedge clk);
      chk(req_ready == 1'b1, {tag, " R1 idle after done"}, req_ready, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) fmem[i] = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
      chk(bus_en == 1'b0, "R1 bus quiet after reset", bus_en, 0);
      chk(done == 1'b0 && ok == 1'b0, "R11 no done after reset", {done, ok}, 0);
      repeat (3) @(negedge clk);
      chk(bus_en == 1'b0, "R1 bus quiet while idle", bus_en, 0);

      run_req(2'b00, 8'h12, 32'h1234_5678, 8, 2, '0, '0, "R4 R5 R2 program ok");
      chk(fmem[8'h12] == 32'h1234_5678, "R4 word programmed", fmem[8'h12], 32'h1234_5678);
      run_req(2'b01, 8'h13, '0, 8, 0, '0, '0, "R3 R6 erase ok");
      chk(fmem[8'h12] == 32'hFFFF_FFFF, "R3 block erased", fmem[8'h12], 32'hFFFF_FFFF);
      run_req(2'b10, 8'h55, '0, 8, 0, '0, '0, "R9 id read");
      chk(id_word0 == ID0, "R9 id word0", id_word0, ID0);
      chk(id_word1 == ID1, "R9 id word1", id_word1, ID1);
      run_req(2'b00, 8'h20, 32'hA5A5_0F0F, 8, 1, 32'h0010_0000, '0, "R8 program fault lane1");
      run_req(2'b00, 8'h21, 32'h0000_FFFF, 8, 0, '0, '0, "R12 clear then program");
      run_req(2'b01, 8'h30, '0, 8, 3, 32'h0000_0020, '0, "R7 erase fault lane0");
      run_req(2'b01, 8'h40, '0, 8, 0, 32'h0010_0010, '0, "R7 R12 erase ignores pgm bit");
      run_req(2'b11, 8'h77, '0, 8, 0, '0, '0, "R9 id read op 11");
      run_req(2'b00, 8'h41, 32'h0000_0001, 3, 5, '0, '0, "R10 timeout");
      run_req(2'b00, 8'h42, 32'h1111_2222, 0, 0, '0, '0, "R10 limit zero one poll");
      run_req(2'b00, 8'h43, 32'h3333_4444, 3, 2, '0, '0, "R10 ready on last poll");
      run_req(2'b00, 8'h44, 32'h5555_6666, 3, 3, '0, '0, "R10 busy equals limit");
      run_req(2'b00, 8'h45, 32'h0000_00FF, 15, 14, '0, '0, "R10 max limit");
      run_req(2'b00, 8'h45, 32'h0000_01FF, 8, 0, '0, '0, "R8 readback mismatch");
      run_req(2'b00, 8'h46, 32'hCAFE_F00D, 8, 0, '0, 32'h0001_0000, "R8 flipped bit");
      run_req(2'b00, 8'h47, 32'hBEEF_0001, 8, 1, '0, '0, "R12 R6 recover");

      repeat (4) @(negedge clk);
      chk(expq.size() == 0, "R6 all bus cycles seen", expq.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule